// File: doc/BRIEF.md
# Multi-Window Inbound DMA Address Translator

This block sits on the inbound path of a host bridge. Each cycle it can accept one 64-bit address issued by a downstream device and turns it into a system address, together with a barrier flag and an MSI flag. If the address cannot be translated, it raises a fault instead. The upper bits of the bus address choose one of five windows. Two windows are direct: a 64-bit pass-through, and a 32-bit window whose upper system bits come from a register held per port. The other three windows look up an entry in a table, using pages of 256 KB, 64 MB or 16 GB.

Two tables hold the entries. The shared table serves 256 KB pages, and its first 64 slots are set aside for 16 GB super pages, 32 slots for each port. A separate table serves 64 MB pages. Entries and the per-port direct registers are loaded through a single write port, selected by table code and index. Each result appears one clock after its request, on registered outputs.

Top module: `dxl_translator`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_valid` high on the next clock. A cycle without a request gives `rsp_valid` low one clock later, with every other output at zero.
- R2: An address with bit 63 set and bits 60:54 all zero uses mode code 0. It returns bits 53:0 as the system address, bit 62 as barrier and bit 61 as MSI, with no fault.
- R3: An address with bit 63 set and any of bits 60:54 set gives a fault, reported with mode code 0.
- R4: Addresses 0x8000_0000 to 0xFFFF_FFFF use mode code 1. The system address is the direct register of `req_port` above bit 29, joined with address bits 29:0. Barrier is address bit 30 and MSI is 0. A write with `wr_sel`=2 loads register `wr_idx[0]` from `wr_data`, and bits 29:0 of the data are dropped.
- R5: A mode 1 request whose direct register is zero gives a fault.
- R6: Addresses 0x0 to 0x7FFF_FFFF use mode code 2. The shared-table index is address bits 29:18, and the system address is entry bits 53:18 joined with address bits 17:0. Barrier is address bit 30 and MSI is entry bit 62.
- R7: A mode 2 index below 64, or at or above the shared-table depth (64+`SHARED_EXTRA`), gives a fault even when that slot is valid.
- R8: Addresses 0x40_0000_0000 to 0x7F_FFFF_FFFF use mode code 3. The 64 MB table is indexed by address bits 37:26, and the system address is entry bits 53:26 joined with address bits 25:0. Barrier is always 0 and MSI is entry bit 62. An index of `M40_DEPTH` or more gives a fault.
- R9: Addresses 0x80_0000_0000 to 0xFF_FFFF_FFFF use mode code 4. The shared-table slot is 32×`req_port` plus address bits 38:34, and the system address is entry bits 53:34 joined with address bits 33:0. Barrier is always 0 and MSI is entry bit 62.
- R10: A table lookup that lands on an entry whose bit 63 (valid) is clear gives a fault. Reset clears every entry and both direct registers.
- R11: An address that lies in none of the five windows gives a fault with mode code 7.
- R12: `wr_sel` 0 writes the shared table and 1 writes the 64 MB table, taking the valid, MSI and page bits from `wr_data`. `wr_sel` 3 writes nothing, and an index past the end of a table writes nothing. A lookup in the same cycle as a write sees the old content; the new content is seen from the next cycle on.
- R13: Whenever `rsp_fault` is high, `rsp_addr`, `rsp_barrier` and `rsp_msi` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_addr | input | 64 | Device-side bus address |
| req_port | input | 1 | Port the request came from (0 or 1) |
| wr_en | input | 1 | Table or register write strobe |
| wr_sel | input | 2 | Write target: 0 shared table, 1 64 MB table, 2 direct register, 3 none |
| wr_idx | input | WR_IDX_W | Entry index, or port number for direct registers |
| wr_data | input | 64 | Entry word: bit 63 valid, bit 62 MSI, low bits page address |
| rsp_valid | output | 1 | Result present |
| rsp_addr | output | SYS_W | Translated system address |
| rsp_barrier | output | 1 | Barrier attribute |
| rsp_msi | output | 1 | MSI attribute |
| rsp_fault | output | 1 | Translation failed |
| rsp_mode | output | 3 | Window code 0..4, or 7 for no window |

## Verification
The properties assume that `rst_n` is released between clock edges, that `req_addr` and `req_port` hold steady through the cycle in which `req_valid` is high, and that `SYS_W` keeps its default of 54, so that a 64-bit direct address fits the output. The bench changes every input on the falling edge, only after reset has been released, and issues at most one write or one request per cycle. The only exception is a single deliberate cycle that carries both, which probes the read-before-write ordering. Every table index the bench drives fits in `wr_idx`.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  typedef enum logic [2:0] {
    WIN_D64  = 3'd0,
    WIN_D32  = 3'd1,
    WIN_M32  = 3'd2,
    WIN_M40  = 3'd3,
    WIN_M40S = 3'd4,
    WIN_NONE = 3'd7
  } win_e;

  typedef enum logic [1:0] {
    SEL_SHARED = 2'd0,
    SEL_M40    = 2'd1,
    SEL_DMAP   = 2'd2,
    SEL_NONE   = 2'd3
  } sel_e;

  localparam int unsigned PORTS          = 2;
  localparam int unsigned SUPER_PER_PORT = 32;
  localparam int unsigned SUPER_TOTAL    = SUPER_PER_PORT * PORTS;
  localparam int unsigned PG_M32_SH      = 18;
  localparam int unsigned PG_M40_SH      = 26;
  localparam int unsigned PG_SUP_SH      = 34;
  localparam int unsigned D32_SH         = 30;
  localparam int unsigned M40_BASE_SH    = 38;
  localparam int unsigned M40S_BASE_SH   = 39;
  localparam int unsigned D64_ADDR_BITS  = 54;

  // Window selection from the address bits alone.
  function automatic win_e window_of(input logic [63:0] a);
    win_e w;
    if (a[63])
      w = WIN_D64;
    else if (a[62:32] == '0 && a[31])
      w = WIN_D32;
    else if (a[62:31] == '0)
      w = WIN_M32;
    else if (a[62:39] == '0 && a[38])
      w = WIN_M40;
    else if (a[62:40] == '0 && a[39])
      w = WIN_M40S;
    else
      w = WIN_NONE;
    return w;
  endfunction

  // Upper part from hi at and above bit sh, lower part from lo.
  function automatic logic [63:0] splice(input logic [63:0] hi,
                                         input logic [63:0] lo,
                                         input int unsigned sh);
    logic [63:0] m;
    m = ~64'd0 << sh;
    return (hi & m) | (lo & ~m);
  endfunction

endpackage

// File: rtl/dxl_window_decode.sv
module dxl_window_decode
  import dxl_pkg::*;
(
  input  logic [63:0] addr,
  output win_e        win,
  output logic        d64_rsvd_bad
);
  assign win          = window_of(addr);
  assign d64_rsvd_bad = addr[63] && (addr[60:D64_ADDR_BITS] != '0);
endmodule

// File: rtl/dxl_entry_table.sv
module dxl_entry_table #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned SYS_W = 54,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic             wr_msi,
  input  logic [SYS_W-1:0] wr_page,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic             rd_msi,
  output logic [SYS_W-1:0] rd_page
);
  logic [DEPTH-1:0]            v_all;
  logic [DEPTH-1:0]            m_all;
  logic [DEPTH-1:0][SYS_W-1:0] pg_all;
  logic                        rd_in_range;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             v_q;
    logic             m_q;
    logic [SYS_W-1:0] pg_q;
    logic             hit;
    assign hit = wr_en && (32'(wr_idx) == i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q  <= 1'b0;
        m_q  <= 1'b0;
        pg_q <= '0;
      end else if (hit) begin
        v_q  <= wr_valid;
        m_q  <= wr_msi;
        pg_q <= wr_page;
      end
    end
    assign v_all[i]  = v_q;
    assign m_all[i]  = m_q;
    assign pg_all[i] = pg_q;
  end

  assign rd_in_range = 32'(rd_idx) < DEPTH;

  always_comb begin
    rd_valid = 1'b0;
    rd_msi   = 1'b0;
    rd_page  = '0;
    if (rd_in_range) begin
      rd_valid = v_all[rd_idx];
      rd_msi   = m_all[rd_idx];
      rd_page  = pg_all[rd_idx];
    end
  end
endmodule

// File: rtl/dxl_dirmap.sv
module dxl_dirmap
  import dxl_pkg::*;
#(
  parameter int unsigned SYS_W = 54
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_port,
  input  logic [SYS_W-1:D32_SH]        wr_hi,
  output logic [PORTS-1:0][SYS_W-1:0]  hi_o
);
  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic [SYS_W-1:D32_SH] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= '0;
      else if (wr_en && (32'(wr_port) == p))
        q <= wr_hi;
    end
    assign hi_o[p] = {q, {D32_SH{1'b0}}};
  end
endmodule

// File: rtl/dxl_translator.sv
module dxl_translator
  import dxl_pkg::*;
#(
  parameter int unsigned SHARED_EXTRA = 64,
  parameter int unsigned M40_DEPTH    = 32,
  parameter int unsigned SYS_W        = 54,
  localparam int unsigned SH_DEPTH    = SUPER_TOTAL + SHARED_EXTRA,
  localparam int unsigned MAX_DEPTH   = (SH_DEPTH > M40_DEPTH) ? SH_DEPTH : M40_DEPTH,
  localparam int unsigned WR_IDX_W    = $clog2(MAX_DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [63:0]         req_addr,
  input  logic                req_port,
  input  logic                wr_en,
  input  logic [1:0]          wr_sel,
  input  logic [WR_IDX_W-1:0] wr_idx,
  input  logic [63:0]         wr_data,
  output logic                rsp_valid,
  output logic [SYS_W-1:0]    rsp_addr,
  output logic                rsp_barrier,
  output logic                rsp_msi,
  output logic                rsp_fault,
  output logic [2:0]          rsp_mode
);
  // Window decode
  win_e win;
  logic d64_rsvd_bad;

  dxl_window_decode u_dec (
    .addr         (req_addr),
    .win          (win),
    .d64_rsvd_bad (d64_rsvd_bad)
  );

  // Write steering
  logic wr_shared, wr_m40, wr_dmap;
  assign wr_shared = wr_en && (wr_sel == SEL_SHARED);
  assign wr_m40    = wr_en && (wr_sel == SEL_M40);
  assign wr_dmap   = wr_en && (wr_sel == SEL_DMAP);

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[61:SYS_W], wr_data[D32_SH-1:0]};

  // Index arithmetic
  logic [31:0]         m32_pg, m40_pg, sup_idx, sh_rd;
  logic [WR_IDX_W-1:0] sh_rd_idx, m40_rd_idx;
  logic                m32_in_range, m40_in_range;

  assign m32_pg       = 32'(req_addr[D32_SH-1:PG_M32_SH]);
  assign m40_pg       = 32'(req_addr[M40_BASE_SH-1:PG_M40_SH]);
  assign sup_idx      = (req_port ? SUPER_PER_PORT : 32'd0)
                      + 32'(req_addr[M40S_BASE_SH-1:PG_SUP_SH]);
  assign sh_rd        = (win == WIN_M40S) ? sup_idx : m32_pg;
  assign sh_rd_idx    = WR_IDX_W'(sh_rd);
  assign m40_rd_idx   = WR_IDX_W'(m40_pg);
  assign m32_in_range = (m32_pg >= SUPER_TOTAL) && (m32_pg < SH_DEPTH);
  assign m40_in_range = m40_pg < M40_DEPTH;

  // Storage
  logic             sh_valid, sh_msi, m40_valid, m40_msi;
  logic [SYS_W-1:0] sh_page, m40_page;
  logic [PORTS-1:0][SYS_W-1:0] dmap_hi;

  dxl_entry_table #(.DEPTH(SH_DEPTH), .SYS_W(SYS_W), .IDX_W(WR_IDX_W)) u_shared (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_shared),
    .wr_idx   (wr_idx),
    .wr_valid (wr_data[63]),
    .wr_msi   (wr_data[62]),
    .wr_page  (wr_data[SYS_W-1:0]),
    .rd_idx   (sh_rd_idx),
    .rd_valid (sh_valid),
    .rd_msi   (sh_msi),
    .rd_page  (sh_page)
  );

  dxl_entry_table #(.DEPTH(M40_DEPTH), .SYS_W(SYS_W), .IDX_W(WR_IDX_W)) u_m40 (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_m40),
    .wr_idx   (wr_idx),
    .wr_valid (wr_data[63]),
    .wr_msi   (wr_data[62]),
    .wr_page  (wr_data[SYS_W-1:0]),
    .rd_idx   (m40_rd_idx),
    .rd_valid (m40_valid),
    .rd_msi   (m40_msi),
    .rd_page  (m40_page)
  );

  dxl_dirmap #(.SYS_W(SYS_W)) u_dmap (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_dmap),
    .wr_port (wr_idx[0]),
    .wr_hi   (wr_data[SYS_W-1:D32_SH]),
    .hi_o    (dmap_hi)
  );

  logic [SYS_W-1:0] dmap_sel;
  assign dmap_sel = dmap_hi[req_port];

  // Translation
  logic        xl_fault, xl_barrier, xl_msi;
  logic [63:0] xl_addr;

  always_comb begin
    xl_fault   = 1'b0;
    xl_barrier = 1'b0;
    xl_msi     = 1'b0;
    xl_addr    = '0;
    unique case (win)
      WIN_D64: begin
        xl_fault   = d64_rsvd_bad;
        xl_addr    = splice(64'd0, req_addr, D64_ADDR_BITS);
        xl_barrier = req_addr[62];
        xl_msi     = req_addr[61];
      end
      WIN_D32: begin
        xl_fault   = (dmap_sel == '0);
        xl_addr    = splice(64'(dmap_sel), req_addr, D32_SH);
        xl_barrier = req_addr[D32_SH];
      end
      WIN_M32: begin
        xl_fault   = !m32_in_range || !sh_valid;
        xl_addr    = splice(64'(sh_page), req_addr, PG_M32_SH);
        xl_barrier = req_addr[D32_SH];
        xl_msi     = sh_msi;
      end
      WIN_M40: begin
        xl_fault   = !m40_in_range || !m40_valid;
        xl_addr    = splice(64'(m40_page), req_addr, PG_M40_SH);
        xl_msi     = m40_msi;
      end
      WIN_M40S: begin
        xl_fault   = !sh_valid;
        xl_addr    = splice(64'(sh_page), req_addr, PG_SUP_SH);
        xl_msi     = sh_msi;
      end
      default: xl_fault = 1'b1;
    endcase
    if (xl_fault) begin
      xl_addr    = '0;
      xl_barrier = 1'b0;
      xl_msi     = 1'b0;
    end
  end

  // Output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_barrier <= 1'b0;
      rsp_msi     <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_mode    <= '0;
    end else if (req_valid) begin
      rsp_valid   <= 1'b1;
      rsp_addr    <= SYS_W'(xl_addr);
      rsp_barrier <= xl_barrier;
      rsp_msi     <= xl_msi;
      rsp_fault   <= xl_fault;
      rsp_mode    <= win;
    end else begin
      rsp_valid   <= 1'b0;
      rsp_addr    <= '0;
      rsp_barrier <= 1'b0;
      rsp_msi     <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_mode    <= '0;
    end
  end
endmodule

module dxl_translator_chk
  import dxl_pkg::*;
#(
  parameter int unsigned SYS_W = 54
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [63:0]      req_addr,
  input logic             rsp_valid,
  input logic [SYS_W-1:0] rsp_addr,
  input logic             rsp_barrier,
  input logic             rsp_msi,
  input logic             rsp_fault,
  input logic [2:0]       rsp_mode
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_addr == '0 && rsp_mode == 3'd0));

  // R2
  d64_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[63] && req_addr[60:54] == '0) |=>
      (!rsp_fault && rsp_addr == SYS_W'($past(req_addr[53:0]))
       && rsp_barrier == $past(req_addr[62]) && rsp_msi == $past(req_addr[61])));

  // R3
  d64_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[63] && req_addr[60:54] != '0) |=> (rsp_fault && rsp_mode == 3'd0));

  // R4
  d32_no_msi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_mode == WIN_D32) |-> !rsp_msi);

  // R8
  wide_no_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_mode == WIN_M40 || rsp_mode == WIN_M40S)) |-> !rsp_barrier);

  // R11
  outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_addr[63] && req_addr[62:40] != '0) |=> (rsp_fault && rsp_mode == WIN_NONE));

  // R13
  fault_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_valid && rsp_addr == '0 && !rsp_barrier && !rsp_msi));
endmodule

bind dxl_translator dxl_translator_chk #(.SYS_W(SYS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .rsp_valid   (rsp_valid),
  .rsp_addr    (rsp_addr),
  .rsp_barrier (rsp_barrier),
  .rsp_msi     (rsp_msi),
  .rsp_fault   (rsp_fault),
  .rsp_mode    (rsp_mode)
);

// File: tb/sim_dxl_translator.sv
`timescale 1ns/100ps
module sim_dxl_translator;
  localparam int SH_N  = 128;
  localparam int M40_N = 32;
  localparam int IW    = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [63:0]   req_addr = '0;
  logic          req_port = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [63:0]   wr_data = '0;
  logic          rsp_valid, rsp_barrier, rsp_msi, rsp_fault;
  logic [53:0]   rsp_addr;
  logic [2:0]    rsp_mode;

  always #2.5 clk = ~clk;

  dxl_translator u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_port(req_port), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_barrier(rsp_barrier), .rsp_msi(rsp_msi), .rsp_fault(rsp_fault),
    .rsp_mode(rsp_mode)
  );

  typedef struct packed {
    logic [53:0] a;
    logic        b;
    logic        m;
    logic        f;
    logic [2:0]  md;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;

  logic [63:0] sh_m [SH_N];
  logic [63:0] m40_m [M40_N];
  logic [63:0] dm [2];

  localparam logic [63:0] K30 = 64'd1 << 30;
  localparam logic [63:0] K18 = 64'd1 << 18;
  localparam logic [63:0] K26 = 64'd1 << 26;
  localparam logic [63:0] K34 = 64'd1 << 34;

  function automatic exp_t model(input logic [63:0] a, input logic p);
    exp_t e;
    logic [63:0] ent, idx, pg;
    e = '0;
    if (a[63]) begin
      e.md = 3'd0;
      if ((a >> 54) % 128 != 0) e.f = 1'b1;
      else begin e.a = a[53:0]; e.b = a[62]; e.m = a[61]; end
    end else if (a >= 64'h8000_0000 && a <= 64'hFFFF_FFFF) begin
      e.md = 3'd1;
      if (dm[p] == 0) e.f = 1'b1;
      else begin pg = dm[p] + (a % K30); e.a = pg[53:0]; e.b = a[30]; end
    end else if (a <= 64'h7FFF_FFFF) begin
      e.md = 3'd2;
      idx = (a % K30) / K18;
      if (idx < 64 || idx >= SH_N) e.f = 1'b1;
      else begin
        ent = sh_m[int'(idx)];
        if (!ent[63]) e.f = 1'b1;
        else begin
          pg = ((ent % (64'd1 << 54)) / K18) * K18 + (a % K18);
          e.a = pg[53:0]; e.b = a[30]; e.m = ent[62];
        end
      end
    end else if (a >= 64'h40_0000_0000 && a <= 64'h7F_FFFF_FFFF) begin
      e.md = 3'd3;
      idx = (a - 64'h40_0000_0000) / K26;
      if (idx >= M40_N) e.f = 1'b1;
      else begin
        ent = m40_m[int'(idx)];
        if (!ent[63]) e.f = 1'b1;
        else begin
          pg = ((ent % (64'd1 << 54)) / K26) * K26 + (a % K26);
          e.a = pg[53:0]; e.m = ent[62];
        end
      end
    end else if (a >= 64'h80_0000_0000 && a <= 64'hFF_FFFF_FFFF) begin
      e.md = 3'd4;
      idx = (p ? 64'd32 : 64'd0) + (a - 64'h80_0000_0000) / K34;
      ent = sh_m[int'(idx)];
      if (!ent[63]) e.f = 1'b1;
      else begin
        pg = ((ent % (64'd1 << 54)) / K34) * K34 + (a % K34);
        e.a = pg[53:0]; e.m = ent[62];
      end
    end else begin
      e.md = 3'd7; e.f = 1'b1;
    end
    return e;
  endfunction

  task automatic shadow_write(input logic [1:0] sel, input int idx, input logic [63:0] d);
    case (sel)
      2'd0: if (idx < SH_N) sh_m[idx] = d;
      2'd1: if (idx < M40_N) m40_m[idx] = d;
      2'd2: dm[idx % 2] = (d % (64'd1 << 54)) / K30 * K30;
      default: ;
    endcase
  endtask

  task automatic do_write(input logic [1:0] sel, input int idx, input logic [63:0] d);
    @(negedge clk);
    req_valid = 1'b0;
    wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = d;
    shadow_write(sel, idx, d);
  endtask

  task automatic lookup(input logic [63:0] a, input logic p, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    req_valid = 1'b1; req_addr = a; req_port = p;
    exp_q.push_back(model(a, p));
    tag_q.push_back(tag);
  endtask

  task automatic wr_look(input logic [1:0] sel, input int idx, input logic [63:0] d,
                         input logic [63:0] a, input logic p, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_port = p;
    exp_q.push_back(model(a, p));
    tag_q.push_back(tag);
    wr_en = 1'b1; wr_sel = sel; wr_idx = IW'(idx); wr_data = d;
    shadow_write(sel, idx, d);
  endtask

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic idle_chk();
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    @(negedge clk);
    // R1: idle cycle leaves outputs quiet
    check(!rsp_valid && !rsp_fault && rsp_addr == '0 && !rsp_barrier && !rsp_msi,
          "R1 idle", {rsp_valid, rsp_fault, rsp_barrier, rsp_msi, 6'd0, rsp_addr}, 64'd0);
  endtask

  // Monitor: scoreboard pop and compare
  always @(negedge clk) begin
    if (rst_n && rsp_valid && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected result", 64'd1, 64'd0);
      end else begin
        exp_t  e;
        exp_t  g;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {rsp_addr, rsp_barrier, rsp_msi, rsp_fault, rsp_mode};
        check(g == e, t, 64'(g), 64'(e));
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < SH_N; i++) sh_m[i] = '0;
    for (int i = 0; i < M40_N; i++) m40_m[i] = '0;
    dm[0] = '0; dm[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!rsp_valid && !rsp_fault && rsp_addr == '0 && rsp_mode == '0, "R1 reset",
          {rsp_valid, rsp_fault, rsp_mode, 5'd0, rsp_addr}, 64'd0);

    lookup(64'h0000_0000_0100_0000, 1'b0, "R10 empty shared entry");
    lookup(64'h0000_0000_8000_1234, 1'b0, "R5 zero direct register");
    lookup(64'hC012_3456_789A_BCDE, 1'b0, "R2 direct64 barrier");
    lookup(64'hA000_0000_0000_0055, 1'b1, "R2 direct64 msi");
    lookup(64'h8200_0000_0000_0000, 1'b0, "R3 reserved bit / R13 zeroed");

    do_write(2'd2, 0, 64'h0000_0012_C000_1234);
    do_write(2'd2, 1, 64'h0000_0004_4000_0000);
    lookup(64'h0000_0000_C000_0100, 1'b0, "R4 port0 with barrier");
    lookup(64'h0000_0000_8000_0200, 1'b1, "R4 port1");

    do_write(2'd0, 70, 64'hC000_0003_1234_5678);
    lookup(64'h0000_0000_4118_1ABC, 1'b0, "R6 table32 hit");

    do_write(2'd0, 10, 64'h8000_0005_0000_0000);
    lookup(64'h0000_0000_0028_0000, 1'b0, "R7 index in super region");
    lookup(64'h0000_0000_0320_0000, 1'b0, "R7 index past depth");

    lookup(64'h0000_00A8_0000_1234, 1'b0, "R9 super page port0");
    lookup(64'h0000_00A8_0000_1234, 1'b1, "R10 super page port1 empty");
    do_write(2'd0, 42, 64'hC000_0008_0000_0000);
    lookup(64'h0000_00A8_0000_1234, 1'b1, "R9 super page port1");

    do_write(2'd1, 5, 64'h8000_0002_0400_0000);
    lookup(64'h0000_0040_1400_0777, 1'b0, "R8 table40 hit");
    lookup(64'h0000_0040_A000_0000, 1'b0, "R8 index past depth");

    lookup(64'h0000_0001_0000_0000, 1'b0, "R11 gap below 40-bit");
    lookup(64'h0000_0100_0000_0000, 1'b1, "R11 above 40-bit");

    do_write(2'd3, 5, 64'd0);
    lookup(64'h0000_0040_1400_0777, 1'b0, "R12 no-target write ignored");
    wr_look(2'd1, 6, 64'h8000_0007_0000_0000, 64'h0000_0040_1800_0010, 1'b0,
            "R12 same-cycle sees old");
    lookup(64'h0000_0040_1800_0010, 1'b0, "R12 next cycle sees new");

    do_write(2'd0, 70, 64'd0);
    lookup(64'h0000_0000_4118_1ABC, 1'b0, "R10 cleared entry");

    idle_chk();
    repeat (2) @(negedge clk);
    // R1: every request answered
    check(exp_q.size() == 0, "R1 all answered", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule